// File: doc/BRIEF.md
# Timer-Driven PWM Generator with 10-Bit Duty

This block produces one pulse-width-modulated output from an 8-bit period timer. The timer runs on a four-clock instruction tick that can be slowed further by a selectable input divider of 1, 4 or 16. The timer counts up to a programmed limit, clears to zero, and starts a new PWM cycle. At each cycle start the output goes high and a 10-bit duty threshold is latched from its holding registers. The output falls when the timer, extended by two sub-count bits, reaches that threshold. Because of the two extra bits, the duty resolution is four times finer than the period step.

A postscaler counts period matches and sets a sticky event flag once every 1 to 16 periods. Software clears the flag with a write. Software programs the block through a single-cycle write port. It writes the period limit, the upper eight duty bits, a mode register that holds the lower two duty bits together with the output and drive enables, and a timer control register. Duty writes made during a cycle never disturb that cycle: only the latched copy drives the comparison.

Top module: `tick_pwm`

## Requirements
- R1: After reset, `pwm_out`, `pwm_oe` and `event_flag` are 0, the timer is stopped and holds 0, and the period limit is 0xFF. Once the timer is started with divide-by-1, a cycle lasts 1024 clocks.
- R2: The write port uses these selects. Select 0 is the period limit P, select 1 the duty upper bits, select 2 the mode register and select 3 the timer control register. In timer control, bits 1:0 pick the divider (0 gives divide-by-1, 1 gives divide-by-4, 2 or 3 give divide-by-16), bit 2 is run and bits 6:3 are the postscale field. One PWM cycle lasts (P+1)·4·divider clocks.
- R3: The duty D is formed as {duty upper byte, mode[5:4]}. In each cycle the output is high for D·divider clocks from the cycle start.
- R4: When D is 0, the output stays low for the whole cycle.
- R5: When D is at least (P+1)·4, the output stays high for the whole cycle.
- R6: A duty write takes effect only at the next cycle start. The cycle in progress keeps its old high time.
- R7: The event flag is set once every (postscale field + 1) period matches. It remains set until it is cleared.
- R8: A write to select 4 clears the event flag. If that write falls on the same clock as a flag-setting match, the flag stays set.
- R9: While run is 0, the timer and the output hold their values and no matches occur.
- R10: Mode bit 0 gates the output: when it is 0, `pwm_out` is 0. Mode bit 1 drives `pwm_oe`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, counted as the oscillator rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe, one register per clock |
| wr_sel | input | 3 | Register select (0 to 4) |
| wr_data | input | 8 | Write data |
| pwm_out | output | 1 | PWM level |
| pwm_oe | output | 1 | Pin drive enable |
| event_flag | output | 1 | Sticky postscaled period-match flag |

## Verification
Two events can land on the same edge: the period match that sets the flag, and a software write that clears it. The bench runs with a postscale of one and a 16-clock cycle. It finds a cycle start from the rising output, then places a clear write on the fourth clock of the cycle, which must leave the flag at 0. A second clear write is placed exactly on the next cycle-start edge. That write is judged right only if the flag reads 1 and the output has just risen.

// File: rtl/tick_pwm_pkg.sv
package tick_pwm_pkg;
   typedef enum logic [2:0] {
      SEL_PERIOD = 3'd0,
      SEL_DUTY   = 3'd1,
      SEL_MODE   = 3'd2,
      SEL_TCTRL  = 3'd3,
      SEL_FCLR   = 3'd4
   } reg_sel_e;

   localparam int MODE_EN_BIT  = 0;
   localparam int MODE_OE_BIT  = 1;
   localparam int MODE_LO_POS  = 4;
   localparam int TC_PS_POS    = 0;
   localparam int TC_RUN_POS   = 2;
   localparam int TC_POST_POS  = 3;
endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
   parameter int SUB_W = 2,
   parameter int N_PS  = 3,
   parameter int SEL_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_i,
   input  logic [SEL_W-1:0] ps_i,
   output logic [SUB_W-1:0] sub_o,
   output logic             last_o
);
   localparam int FC_W = SUB_W * N_PS;

   logic [FC_W-1:0]  fc_q;
   logic [SUB_W-1:0] sub_opt [N_PS];
   logic [N_PS-1:0]  last_opt;
   logic [SEL_W-1:0] idx;

   // option k: fine counter wraps after 2^(SUB_W*(k+1)) clocks
   for (genvar k = 0; k < N_PS; k++) begin : g_opt
      assign sub_opt[k]  = fc_q[k*SUB_W +: SUB_W];
      assign last_opt[k] = &fc_q[SUB_W*(k+1)-1:0];
   end

   always_comb begin
      if (int'(ps_i) > N_PS - 1) idx = SEL_W'(N_PS - 1);
      else                       idx = ps_i;
   end

   assign sub_o  = sub_opt[idx];
   assign last_o = last_opt[idx];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      fc_q <= '0;
      else if (run_i)  fc_q <= last_o ? '0 : fc_q + 1'b1;
   end
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
   parameter int TMR_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_i,
   input  logic             tick_i,
   input  logic [TMR_W-1:0] period_i,
   output logic [TMR_W-1:0] tmr_o,
   output logic             match_o
);
   logic [TMR_W-1:0] tmr_q;

   assign match_o = run_i && tick_i && (tmr_q == period_i);
   assign tmr_o   = tmr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                tmr_q <= '0;
      else if (run_i && tick_i)  tmr_q <= match_o ? '0 : tmr_q + 1'b1;
   end

   p_wrap_to_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      match_o |=> (tmr_q == '0));
   p_hold_when_stopped_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !run_i |=> $stable(tmr_q));
endmodule

// File: rtl/pwm_duty_unit.sv
module pwm_duty_unit #(
   parameter int DUTY_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run_i,
   input  logic              match_i,
   input  logic [DUTY_W-1:0] duty_req_i,
   input  logic [DUTY_W-1:0] count_i,
   output logic              level_o
);
   logic [DUTY_W-1:0] duty_lat;
   logic              out_q;
   logic              hit;

   assign hit     = (count_i == duty_lat);
   // fall in the very clock the count reaches the threshold
   assign level_o = out_q && !hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         duty_lat <= '0;
         out_q    <= 1'b0;
      end else if (match_i) begin
         duty_lat <= duty_req_i;
         out_q    <= (duty_req_i != '0);
      end else if (run_i && hit) begin
         out_q    <= 1'b0;
      end
   end

   p_duty_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !match_i |=> $stable(duty_lat));
   p_zero_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (duty_lat == '0) |-> !level_o);
endmodule

// File: rtl/pwm_postscaler.sv
module pwm_postscaler #(
   parameter int POST_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              match_i,
   input  logic [POST_W-1:0] post_sel_i,
   input  logic              clr_i,
   output logic              flag_o
);
   logic [POST_W-1:0] post_q;
   logic              wrap;

   assign wrap = match_i && (post_q >= post_sel_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         post_q <= '0;
         flag_o <= 1'b0;
      end else begin
         if (match_i) post_q <= wrap ? '0 : post_q + 1'b1;
         if (wrap)       flag_o <= 1'b1;
         else if (clr_i) flag_o <= 1'b0;
      end
   end

   p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_o && !clr_i) |=> flag_o);
   p_flag_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_o) |-> $past(match_i));
   p_set_beats_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (match_i && clr_i && post_sel_i == '0) |=> flag_o);
endmodule

// File: rtl/tick_pwm.sv
module tick_pwm
   import tick_pwm_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int TMR_W  = 8,
   parameter int SUB_W  = 2,
   parameter int N_PS   = 3,
   parameter int PS_W   = 2,
   parameter int POST_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [2:0]        wr_sel,
   input  logic [DATA_W-1:0] wr_data,
   output logic              pwm_out,
   output logic              pwm_oe,
   output logic              event_flag
);
   localparam int DUTY_W = TMR_W + SUB_W;

   if (TMR_W > DATA_W) begin : g_bad_tmr
      $error("timer wider than write data");
   end
   if (MODE_LO_POS + SUB_W > DATA_W || TC_POST_POS + POST_W > DATA_W) begin : g_bad_fields
      $error("register fields exceed write data width");
   end
   if ((1 << PS_W) < N_PS) begin : g_bad_ps
      $error("prescale select too narrow for option count");
   end

   logic [TMR_W-1:0]  period_q;
   logic [TMR_W-1:0]  duty_hi_q;
   logic [SUB_W-1:0]  duty_lo_q;
   logic              mode_en_q;
   logic              mode_oe_q;
   logic [PS_W-1:0]   ps_q;
   logic              run_q;
   logic [POST_W-1:0] post_q;
   logic              clr_stb;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         period_q  <= '1;
         duty_hi_q <= '0;
         duty_lo_q <= '0;
         mode_en_q <= 1'b0;
         mode_oe_q <= 1'b0;
         ps_q      <= '0;
         run_q     <= 1'b0;
         post_q    <= '0;
      end else if (wr_en) begin
         case (reg_sel_e'(wr_sel))
            SEL_PERIOD: period_q  <= wr_data[TMR_W-1:0];
            SEL_DUTY:   duty_hi_q <= wr_data[TMR_W-1:0];
            SEL_MODE: begin
               duty_lo_q <= wr_data[MODE_LO_POS +: SUB_W];
               mode_en_q <= wr_data[MODE_EN_BIT];
               mode_oe_q <= wr_data[MODE_OE_BIT];
            end
            SEL_TCTRL: begin
               ps_q   <= wr_data[TC_PS_POS +: PS_W];
               run_q  <= wr_data[TC_RUN_POS];
               post_q <= wr_data[TC_POST_POS +: POST_W];
            end
            default: ;
         endcase
      end
   end

   assign clr_stb = wr_en && (wr_sel == SEL_FCLR);

   logic [SUB_W-1:0] sub;
   logic             tick;
   logic [TMR_W-1:0] tmr;
   logic             match;
   logic             level;

   pwm_prescaler #(.SUB_W(SUB_W), .N_PS(N_PS), .SEL_W(PS_W)) u_pre (
      .clk(clk), .rst_n(rst_n), .run_i(run_q), .ps_i(ps_q),
      .sub_o(sub), .last_o(tick)
   );

   pwm_timebase #(.TMR_W(TMR_W)) u_tb (
      .clk(clk), .rst_n(rst_n), .run_i(run_q), .tick_i(tick),
      .period_i(period_q), .tmr_o(tmr), .match_o(match)
   );

   pwm_duty_unit #(.DUTY_W(DUTY_W)) u_duty (
      .clk(clk), .rst_n(rst_n), .run_i(run_q), .match_i(match),
      .duty_req_i({duty_hi_q, duty_lo_q}), .count_i({tmr, sub}),
      .level_o(level)
   );

   pwm_postscaler #(.POST_W(POST_W)) u_post (
      .clk(clk), .rst_n(rst_n), .match_i(match), .post_sel_i(post_q),
      .clr_i(clr_stb), .flag_o(event_flag)
   );

   assign pwm_out = mode_en_q && level;
   assign pwm_oe  = mode_oe_q;

   p_no_match_stopped_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !run_q |-> !match);
   p_oe_follows_mode_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == SEL_MODE) |=> (pwm_oe == $past(wr_data[MODE_OE_BIT])));
endmodule

// File: tb/tick_pwm_tb.sv
module tick_pwm_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [2:0] wr_sel = '0;
   logic [7:0] wr_data = '0;
   logic       pwm_out, pwm_oe, event_flag;
   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #4 clk = ~clk;

   tick_pwm u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .pwm_out(pwm_out), .pwm_oe(pwm_oe),
      .event_flag(event_flag)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] s, input logic [7:0] d);
      @(negedge clk); wr_en = 1'b1; wr_sel = s; wr_data = d;
      @(negedge clk); wr_en = 1'b0;
   endtask

   // measures one cycle from a rise; optional duty write at offset wr_at
   task automatic measure(input bit have_rise, input int wr_at, input logic [7:0] wv,
                          output int hi, output int per);
      bit found, fell, prev;
      int idx;
      hi = -1; per = -1; found = have_rise; prev = 1'b1;
      for (int t = 0; t < 40000 && !found; t++) begin
         @(negedge clk);
         if (!prev && pwm_out) found = 1'b1;
         prev = pwm_out;
      end
      if (!found) return;
      hi = 1; idx = 0; fell = 1'b0;
      for (int t = 0; t < 40000; t++) begin
         if (idx == wr_at) begin wr_en = 1'b1; wr_sel = 3'd1; wr_data = wv; end
         @(negedge clk); wr_en = 1'b0; idx++;
         if (pwm_out) begin
            if (fell) begin per = idx; break; end
            hi++;
         end else fell = 1'b1;
      end
   endtask

   task automatic count_high(input int n, output int highs);
      highs = 0;
      for (int i = 0; i < n; i++) begin @(negedge clk); if (pwm_out) highs++; end
   endtask

   task automatic t_reset();
      int hi, per, highs;
      chk(pwm_out == 0, "R1 out", pwm_out, 0);
      chk(pwm_oe == 0, "R1 oe", pwm_oe, 0);
      chk(event_flag == 0, "R1 flag", event_flag, 0);
      wr(3'd2, 8'h03); wr(3'd1, 8'h10);
      count_high(300, highs);
      chk(highs == 0, "R1 stopped", highs, 0);
      wr(3'd3, 8'h04);
      measure(0, -1, 0, hi, per);
      chk(per == 1024, "R1 period FF", per, 1024);
   endtask

   task automatic t_div1();
      int hi, per;
      wr(3'd0, 8'h3F); wr(3'd1, 8'd25); wr(3'd2, 8'h13); wr(3'd3, 8'h04);
      measure(0, -1, 0, hi, per);
      measure(1, -1, 0, hi, per);
      chk(per == 256, "R2 div1 period", per, 256);
      chk(hi == 101, "R3 div1 high", hi, 101);
   endtask

   task automatic t_div4();
      int hi, per;
      wr(3'd0, 8'h0F); wr(3'd1, 8'd5); wr(3'd2, 8'h03); wr(3'd3, 8'h05);
      measure(0, -1, 0, hi, per);
      measure(1, -1, 0, hi, per);
      chk(per == 256, "R2 div4 period", per, 256);
      chk(hi == 80, "R3 div4 high", hi, 80);
   endtask

   task automatic t_div16();
      int hi, per;
      wr(3'd0, 8'h03); wr(3'd1, 8'd1); wr(3'd2, 8'h13); wr(3'd3, 8'h06);
      measure(0, -1, 0, hi, per);
      measure(1, -1, 0, hi, per);
      chk(per == 256, "R2 div16 period", per, 256);
      chk(hi == 80, "R3 div16 high", hi, 80);
      wr(3'd3, 8'h07);
      measure(0, -1, 0, hi, per);
      measure(1, -1, 0, hi, per);
      chk(per == 256, "R2 field3 period", per, 256);
   endtask

   task automatic t_reload();
      int hi, per;
      wr(3'd0, 8'h3F); wr(3'd1, 8'd25); wr(3'd2, 8'h03); wr(3'd3, 8'h04);
      measure(0, -1, 0, hi, per);
      measure(1, 20, 8'd10, hi, per);
      chk(hi == 100, "R6 old duty kept", hi, 100);
      measure(1, -1, 0, hi, per);
      chk(hi == 40, "R6 new duty", hi, 40);
   endtask

   task automatic t_zero();
      int highs;
      wr(3'd0, 8'h07); wr(3'd1, 8'd0); wr(3'd2, 8'h03); wr(3'd3, 8'h04);
      repeat (100) @(negedge clk);
      count_high(200, highs);
      chk(highs == 0, "R4 zero duty", highs, 0);
   endtask

   task automatic t_over();
      int highs;
      wr(3'd0, 8'h07); wr(3'd1, 8'd250); wr(3'd2, 8'h03); wr(3'd3, 8'h04);
      repeat (100) @(negedge clk);
      count_high(64, highs);
      chk(highs == 64, "R5 over period", highs, 64);
   endtask

   task automatic t_post();
      time t1, t2;
      int w;
      wr(3'd0, 8'h03); wr(3'd1, 8'd1); wr(3'd2, 8'h03); wr(3'd3, 8'h14);
      wr(3'd4, 8'h00);
      w = 0; while (!event_flag && w < 5000) begin @(negedge clk); w++; end
      t1 = $time;
      repeat (30) @(negedge clk);
      chk(event_flag == 1, "R7 sticky", event_flag, 1);
      wr(3'd4, 8'h00);
      chk(event_flag == 0, "R8 clear", event_flag, 0);
      w = 0; while (!event_flag && w < 5000) begin @(negedge clk); w++; end
      t2 = $time;
      chk((t2 - t1) == 48 * 8, "R7 postscale 3", int'((t2 - t1) / 8), 48);
   endtask

   task automatic t_collide();
      int hi, per;
      wr(3'd3, 8'h04);
      measure(0, -1, 0, hi, per);
      repeat (3) @(negedge clk);
      wr_en = 1'b1; wr_sel = 3'd4; wr_data = 8'h00;
      @(negedge clk); wr_en = 1'b0;
      chk(event_flag == 0, "R8 mid clear", event_flag, 0);
      repeat (11) @(negedge clk);
      wr_en = 1'b1; wr_sel = 3'd4;
      @(negedge clk); wr_en = 1'b0;
      chk(event_flag == 1, "R8 set wins", event_flag, 1);
      chk(pwm_out == 1, "R8 cycle start", pwm_out, 1);
   endtask

   task automatic t_stop();
      logic v;
      int diffs = 0;
      wr(3'd3, 8'h00); wr(3'd4, 8'h00);
      v = pwm_out;
      for (int i = 0; i < 200; i++) begin
         @(negedge clk);
         if (pwm_out != v || event_flag) diffs++;
      end
      chk(diffs == 0, "R9 frozen", diffs, 0);
      wr(3'd3, 8'h04);
   endtask

   task automatic t_mode();
      int highs, hi, per;
      wr(3'd2, 8'h02);
      count_high(100, highs);
      chk(highs == 0, "R10 gated", highs, 0);
      chk(pwm_oe == 1, "R10 oe on", pwm_oe, 1);
      wr(3'd2, 8'h01);
      chk(pwm_oe == 0, "R10 oe off", pwm_oe, 0);
      measure(0, -1, 0, hi, per);
      chk(per == 16, "R10 enabled runs", per, 16);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_div1();
      t_div4();
      t_div16();
      t_reload();
      t_zero();
      t_over();
      t_post();
      t_collide();
      t_stop();
      t_mode();
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(8 * 200000);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog actual=0 expected=1");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule